// File: doc/BRIEF.md
# Reference Mode Supervisor for a Disciplined System Clock

This block is the supervisor that sits above a disciplined system clock fed by two reference inputs. It takes a 2-bit mode request and, once that request has held steady, commits to free run, reference 1, reference 2 or hold over. The selected mode is reported on a 2-bit status output. From the committed mode and a few condition flags it tells the loop filter and the frequency synthesiser which source to follow: live reference tracking, the averaged hold-over value, the last output value, or the nominal free-run setting.

Every selection of a reference starts a fast-acquisition phase. That phase is timed in whole seconds from a seconds tick and ends after a set number of seconds. A large phase error during normal locked operation starts the phase again. While a reference is present and selected, a qualification timer runs. When it completes it raises a hold-over-good flag and marks an averaged value as usable. Any later entry into hold over then uses that average, where an earlier entry would fall back to the nominal frequency. If the selected reference disappears, the mode stays as requested and the loss is flagged, and the output freezes at its last value. The loop filter, synthesiser and oscillator are outside this block.

Top module: `refclk_mode_ctrl`

## Requirements
- R1: Request and status share one encoding: 2'b00 free run, 2'b01 reference 1, 2'b10 reference 2, 2'b11 hold over. After the asynchronous active-low reset, status is 2'b00, hold_good is 0 and src_sel is nominal.
- R2: A new request changes status only after it has been sampled unchanged on SETTLE_CYC+1 consecutive clock edges. A request held for only SETTLE_CYC cycles leaves status unchanged.
- R3: Committing to reference 1 or 2 starts fast acquisition. mode_alarm stays high until ACQ_SECS second pulses have been counted in that mode, then falls.
- R4: In a reference mode with acquisition finished and the reference present, phase_err_big restarts fast acquisition. mode_alarm is high from the next cycle for another full ACQ_SECS seconds.
- R5: mode_alarm is high whenever status is free run or hold over.
- R6: hold_good rises on the QUAL_SECS-th second pulse counted in a reference mode while ref_lost is low. Pulses seen while ref_lost is high are not counted.
- R7: Every mode commit clears hold_good and restarts qualification. A second pulse in the same cycle as the commit is not counted.
- R8: src_sel encoding is 2'b00 track, 2'b01 average, 2'b10 last value, 2'b11 nominal. Free run selects nominal. A reference mode with the reference present selects track.
- R9: Hold over selects nominal if no qualification has completed since reset. After the first completed qualification, hold over selects average until the next reset.
- R10: With ref_lost high in a reference mode, status keeps the requested mode, lor_ind is 1 and src_sel is last value. The loss alone does not raise mode_alarm.
- R11: rfl_alarm follows freq_limit with one clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode |
| sec_tick | input | 1 | One-cycle pulse per tick of the seconds base |
| ref_lost | input | 1 | Selected reference is absent |
| phase_err_big | input | 1 | Loop phase error above the re-acquire limit |
| freq_limit | input | 1 | Output frequency beyond the pull limit |
| status | output | 2 | Committed mode |
| mode_alarm | output | 1 | Not in normal locked operation |
| hold_good | output | 1 | Qualified hold-over average available |
| lor_ind | output | 1 | Loss of the selected reference |
| rfl_alarm | output | 1 | Registered frequency-limit alarm |
| src_sel | output | 2 | Frequency source for the loop and synthesiser |

## Verification
A mode commit and a second pulse can arrive in the same clock cycle. In that case the commit's restart of qualification must win over the count. The bench provokes this by switching between the two references and placing the second pulse exactly on the edge where the debounced request commits. It then counts QUAL_SECS-1 further seconds with hold_good expected low, and one more with hold_good expected high. A phase-error restart arriving while the reference is lost is also covered: the bench checks that no restart happens.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   typedef enum logic [1:0] {
      MODE_FREE = 2'b00,
      MODE_REF1 = 2'b01,
      MODE_REF2 = 2'b10,
      MODE_HOLD = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      SRC_TRACK = 2'b00,
      SRC_AVG   = 2'b01,
      SRC_LAST  = 2'b10,
      SRC_NOM   = 2'b11
   } src_e;

   function automatic logic is_ref(logic [1:0] m);
      return (m == MODE_REF1) || (m == MODE_REF2);
   endfunction
endpackage

// File: rtl/refclk_req_filter.sv
module refclk_req_filter #(
   parameter int SETTLE_CYC = 750_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   input  logic [1:0] cur,
   output logic       commit,
   output logic [1:0] pend
);
   localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 2'b00;
         cnt_q <= '0;
      end else if (req != pend) begin
         pend  <= req;
         cnt_q <= '0;
      end else if (cnt_q != LIM) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign commit = (req == pend) && (cnt_q == LIM) && (pend != cur);
endmodule

// File: rtl/refclk_sec_base.sv
module refclk_sec_base #(
   parameter int TICKS_PER_SEC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   output logic sec_pulse
);
   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign sec_pulse = sec_tick;
      end else begin : g_div
         localparam int DW = $clog2(TICKS_PER_SEC);
         localparam logic [DW-1:0] DLIM = DW'(TICKS_PER_SEC - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (sec_tick)
               div_q <= (div_q == DLIM) ? '0 : div_q + 1'b1;
         end
         assign sec_pulse = sec_tick && (div_q == DLIM);
      end
   endgenerate
endmodule

// File: rtl/refclk_sec_timer.sv
module refclk_sec_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic sec_pulse,
   output logic done
);
   localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [TW-1:0] TLIM = TW'(LIMIT - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (run && sec_pulse && !done) begin
         if (cnt_q == TLIM)
            done <= 1'b1;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/refclk_mode_ctrl.sv
module refclk_mode_ctrl
   import refclk_pkg::*;
#(
   parameter int SETTLE_CYC    = 750_000,
   parameter int ACQ_SECS      = 100,
   parameter int QUAL_SECS     = 101,
   parameter int TICKS_PER_SEC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req,
   input  logic       sec_tick,
   input  logic       ref_lost,
   input  logic       phase_err_big,
   input  logic       freq_limit,
   output logic [1:0] status,
   output logic       mode_alarm,
   output logic       hold_good,
   output logic       lor_ind,
   output logic       rfl_alarm,
   output logic [1:0] src_sel
);
   generate
      if (SETTLE_CYC < 1)    begin : g_bad_settle $error("SETTLE_CYC must be at least 1"); end
      if (ACQ_SECS < 1)      begin : g_bad_acq    $error("ACQ_SECS must be at least 1"); end
      if (QUAL_SECS < 1)     begin : g_bad_qual   $error("QUAL_SECS must be at least 1"); end
      if (TICKS_PER_SEC < 1) begin : g_bad_div    $error("TICKS_PER_SEC must be at least 1"); end
   endgenerate

   mode_e      mode_q;
   logic       avg_valid_q;
   logic       rfl_q;
   logic       commit;
   logic [1:0] pend;
   logic       sec_pulse;
   logic       acq_done, qual_done;
   logic       ref_mode, phase_restart, acq_restart;

   refclk_req_filter #(.SETTLE_CYC(SETTLE_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .req(mode_req), .cur(mode_q),
      .commit(commit), .pend(pend)
   );

   refclk_sec_base #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sbase (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sec_pulse(sec_pulse)
   );

   assign ref_mode      = is_ref(mode_q);
   assign phase_restart = !commit && ref_mode && acq_done && !ref_lost && phase_err_big;
   assign acq_restart   = (commit && is_ref(pend)) || phase_restart;

   refclk_sec_timer #(.LIMIT(ACQ_SECS)) u_acq (
      .clk(clk), .rst_n(rst_n), .restart(acq_restart), .run(ref_mode),
      .sec_pulse(sec_pulse), .done(acq_done)
   );

   refclk_sec_timer #(.LIMIT(QUAL_SECS)) u_qual (
      .clk(clk), .rst_n(rst_n), .restart(commit), .run(ref_mode && !ref_lost),
      .sec_pulse(sec_pulse), .done(qual_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MODE_FREE;
         avg_valid_q <= 1'b0;
         rfl_q       <= 1'b0;
      end else begin
         rfl_q <= freq_limit;
         if (commit)
            mode_q <= mode_e'(pend);
         if (qual_done)
            avg_valid_q <= 1'b1;
      end
   end

   always_comb begin
      case (mode_q)
         MODE_FREE: src_sel = SRC_NOM;
         MODE_HOLD: src_sel = avg_valid_q ? SRC_AVG : SRC_NOM;
         default:   src_sel = ref_lost ? SRC_LAST : SRC_TRACK;
      endcase
   end

   assign status     = mode_q;
   assign mode_alarm = !ref_mode || !acq_done;
   assign hold_good  = qual_done;
   assign lor_ind    = ref_mode && ref_lost;
   assign rfl_alarm  = rfl_q;
endmodule

// File: rtl/refclk_mode_ctrl_chk.sv
module refclk_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_req,
   input logic [1:0] status,
   input logic       mode_alarm,
   input logic       hold_good,
   input logic       lor_ind,
   input logic [1:0] src_sel
);
   // R5
   alarm_low_only_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_alarm |-> (status == 2'b01 || status == 2'b10));

   // R8
   free_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b00) |-> (src_sel == 2'b11));

   // R6
   good_rise_in_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_good) |-> (status == 2'b01 || status == 2'b10));

   // R7
   change_clears_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status) |-> !hold_good);

   // R2
   status_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status) |-> (status == $past(mode_req)));

   // R10
   lost_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lor_ind |-> (src_sel == 2'b10));

   // R9
   avg_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == 2'b01) |-> (status == 2'b11));
endmodule

bind refclk_mode_ctrl refclk_mode_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .status(status),
   .mode_alarm(mode_alarm), .hold_good(hold_good), .lor_ind(lor_ind),
   .src_sel(src_sel)
);

// File: tb/refclk_mode_ctrl_tb.sv
module refclk_mode_ctrl_tb;
   localparam int S   = 8;
   localparam int ACQ = 100;
   localparam int QL  = 101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_req = 2'b00;
   logic       sec_tick = 1'b0, ref_lost = 1'b0, phase_err_big = 1'b0, freq_limit = 1'b0;
   logic [1:0] status, src_sel;
   logic       mode_alarm, hold_good, lor_ind, rfl_alarm;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   refclk_mode_ctrl #(.SETTLE_CYC(S), .ACQ_SECS(ACQ), .QUAL_SECS(QL), .TICKS_PER_SEC(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .sec_tick(sec_tick),
      .ref_lost(ref_lost), .phase_err_big(phase_err_big), .freq_limit(freq_limit),
      .status(status), .mode_alarm(mode_alarm), .hold_good(hold_good),
      .lor_ind(lor_ind), .rfl_alarm(rfl_alarm), .src_sel(src_sel)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic secs(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) sec_tick = 1'b1;
         @(negedge clk) sec_tick = 1'b0;
      end
   endtask

   task automatic set_mode(logic [1:0] m);
      @(negedge clk) mode_req = m;
      repeat (S + 3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset status", status, 0);
      check("R1 reset hold_good", hold_good, 0);
      check("R1 reset src nominal", src_sel, 3);
      check("R5 alarm in free run", mode_alarm, 1);
   endtask

   task automatic t_glitch();
      @(negedge clk) mode_req = 2'b01;
      repeat (S) @(negedge clk);
      mode_req = 2'b00;
      repeat (4) @(negedge clk);
      check("R2 short request ignored", status, 0);
   endtask

   task automatic t_hold_early();
      set_mode(2'b11);
      check("R1 hold status", status, 3);
      check("R9 early hold nominal", src_sel, 3);
      check("R5 alarm in hold", mode_alarm, 1);
   endtask

   task automatic t_ref_acq();
      set_mode(2'b01);
      check("R1 ref1 status", status, 1);
      check("R3 alarm at entry", mode_alarm, 1);
      check("R8 tracking", src_sel, 0);
      secs(ACQ - 1);
      check("R3 alarm before end", mode_alarm, 1);
      secs(1);
      check("R3 alarm after acquisition", mode_alarm, 0);
      check("R6 good not yet", hold_good, 0);
      secs(QL - ACQ);
      check("R6 good on qualifying second", hold_good, 1);
   endtask

   task automatic t_lor();
      @(negedge clk) ref_lost = 1'b1;
      phase_err_big = 1'b1;
      @(negedge clk) phase_err_big = 1'b0;
      check("R10 lor_ind", lor_ind, 1);
      check("R10 last value", src_sel, 2);
      check("R10 status kept", status, 1);
      check("R10 no alarm on loss", mode_alarm, 0);
      secs(3);
      @(negedge clk) ref_lost = 1'b0;
      @(negedge clk);
      check("R10 lor clear", lor_ind, 0);
      check("R4 no restart while lost", mode_alarm, 0);
   endtask

   task automatic t_phase();
      @(negedge clk) phase_err_big = 1'b1;
      @(negedge clk) phase_err_big = 1'b0;
      check("R4 restart alarm", mode_alarm, 1);
      secs(ACQ - 1);
      check("R4 alarm before end", mode_alarm, 1);
      secs(1);
      check("R4 alarm after reacquire", mode_alarm, 0);
      check("R4 good kept", hold_good, 1);
   endtask

   task automatic t_hold_late();
      set_mode(2'b11);
      check("R7 good cleared on change", hold_good, 0);
      check("R9 hold uses average", src_sel, 1);
   endtask

   task automatic t_lost_qual();
      @(negedge clk) ref_lost = 1'b1;
      set_mode(2'b10);
      check("R1 ref2 status", status, 2);
      secs(50);
      @(negedge clk) ref_lost = 1'b0;
      secs(QL - 1);
      check("R6 lost seconds not counted", hold_good, 0);
      secs(1);
      check("R6 good after present seconds", hold_good, 1);
   endtask

   task automatic t_coincide();
      @(negedge clk) mode_req = 2'b01;
      repeat (S) @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      check("R7 commit on tick", status, 1);
      check("R7 good cleared", hold_good, 0);
      secs(QL - 1);
      check("R7 commit tick not counted", hold_good, 0);
      secs(1);
      check("R7 good after full count", hold_good, 1);
   endtask

   task automatic t_rfl();
      @(negedge clk) freq_limit = 1'b1;
      check("R11 not yet", rfl_alarm, 0);
      @(negedge clk);
      check("R11 follows", rfl_alarm, 1);
      freq_limit = 1'b0;
      @(negedge clk);
      check("R11 clears", rfl_alarm, 0);
   endtask

   task automatic t_reset_mid();
      set_mode(2'b00);
      check("R8 free nominal", src_sel, 3);
      check("R5 free alarm", mode_alarm, 1);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      set_mode(2'b11);
      check("R9 average forgotten after reset", src_sel, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_glitch();
      t_hold_early();
      t_ref_acq();
      t_lor();
      t_phase();
      t_hold_late();
      t_lost_qual();
      t_coincide();
      t_rfl();
      t_reset_mid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150_000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule